// File: doc/BRIEF.md
# Cartridge Program Bank Register and FM Sound Chip Decoder

This block is the bus-facing logic of a small game-cartridge mapper for an 8-bit console. It watches the CPU address bus, the data bus, the read/write line and the CPU phase-2 clock. From these it keeps one write-only bank register, which picks a 32 KiB window of program ROM. The CPU sees that window across the whole $8000-$FFFF range. The block also generates the enable and address/data select for an external FM synthesis chip. That chip is reached by writes to $9010 (register index) and $9030 (register data).

Both write decoders use partial address patterns, so many addresses alias onto each target. The bank register captures its data in the cycle of the CPU phase-2 falling edge. The bus values it stores are the ones held while phase 2 was high, because the data bus is stable at that point. A configuration input sets whether the top ROM address line is driven by the register or held high. Holding it high lets a 128 KiB or 256 KiB device sit in a socket wired for 512 KiB. The logic runs on a fast system clock that oversamples the phase-2 signal.

Top module: `cart_prg_fm_mapper`

## Requirements
- R1: A CPU cycle is a bank write when cpu_rw=0, cpu_phi2=1 and the address has bit15=1, bits14..12=000 and bits6..4=000. Bits 11..7 and 3..0 are ignored (for example $8000 and $8F8F both hit).
- R2: The bank register loads cpu_data[3:0] in the first system clock after cpu_phi2 is seen going low, when the phase-2-high part of that cycle was a bank write. The loaded value is the data held while phase 2 was high, not the bus value after the fall. At all other times the register holds.
- R3: fm_en is 1 exactly when cpu_rw=0, cpu_phi2=1 and the address has bit15=1, bits14..13=00, bit12=1, bits7..6=00 and bit4=1. Other bits are ignored, so $9010, $9030 and $9F1F all enable the chip.
- R4: fm_sel equals address bit5: 0 selects the register-index port ($9010) and 1 selects the data port ($9030).
- R5: After reset the bank register holds the last bank (all ones, 15 for 4 bits), so the reset vector at the top of the window comes from the last bank.
- R6: prg_addr[3:0] drives ROM address lines A15..A18 from the bank register. When big_rom_en=0, prg_addr[3] (A18) is forced to 1.
- R7: rom_en is 1 exactly when cpu_rw=1 and address bit15=1. It is 0 during every write and for reads below $8000.
- R8: A write that differs from the bank pattern in any fixed bit leaves the bank register unchanged. This includes writes to FM addresses, $8010, $C000, and reads of $8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples phase 2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_phi2 | input | 1 | CPU phase-2 clock |
| big_rom_en | input | 1 | 1 = register drives A18, 0 = A18 held high |
| prg_addr | output | 4 | ROM address lines A15..A18 |
| rom_en | output | 1 | Program ROM enable for CPU reads |
| fm_en | output | 1 | FM chip enable |
| fm_sel | output | 1 | FM chip address/data select |

## Verification
Two things fall in the same system clock: the bank register capturing the previous bus cycle, and the start of the next bus cycle. On the phase-2 fall, the bench at once replaces the address with $0000, the data with $FF and the read/write line with read. It then checks that the bank holds the value written while phase 2 was high, not the new bus contents. The same pattern is used for aliasing and rejected writes, so every change of the bank is judged against a write that ended with the bus already moved on.

// File: rtl/cart_pkg.sv
package cart_pkg;
    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned PRG_BANK_W = 4;
    // bank register decode: 1000_xxxx_x000_xxxx
    localparam logic [ADDR_W-1:0] BANK_MASK  = 16'hF070;
    localparam logic [ADDR_W-1:0] BANK_MATCH = 16'h8000;
    // FM chip decode: 1001_xxxx_00x1_xxxx
    localparam logic [ADDR_W-1:0] FM_MASK    = 16'hF0D0;
    localparam logic [ADDR_W-1:0] FM_MATCH   = 16'h9010;
    localparam int unsigned FM_SEL_BIT = 5;
endpackage

// File: rtl/cart_addr_decode.sv
module cart_addr_decode #(
    parameter int unsigned ADDR_W     = cart_pkg::ADDR_W,
    parameter logic [ADDR_W-1:0] BANK_MASK  = cart_pkg::BANK_MASK,
    parameter logic [ADDR_W-1:0] BANK_MATCH = cart_pkg::BANK_MATCH,
    parameter logic [ADDR_W-1:0] FM_MASK    = cart_pkg::FM_MASK,
    parameter logic [ADDR_W-1:0] FM_MATCH   = cart_pkg::FM_MATCH,
    parameter int unsigned FM_SEL_BIT = cart_pkg::FM_SEL_BIT
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    input  logic              phi2,
    output logic              bank_hit,
    output logic              fm_hit,
    output logic              fm_sel,
    output logic              rom_rd
);
    logic wr_strobe;

    always_comb begin
        wr_strobe = phi2 && !rw;
        bank_hit  = wr_strobe && ((addr & BANK_MASK) == BANK_MATCH);
        fm_hit    = wr_strobe && ((addr & FM_MASK) == FM_MATCH);
        fm_sel    = addr[FM_SEL_BIT];
        rom_rd    = rw && addr[ADDR_W-1];
    end

    // R1/R3: the two write targets never alias onto each other
    always_comb begin
        assert_decode_exclusive_R1: assert (!(bank_hit && fm_hit))
            else $error("bank and FM decode both active");
    end
endmodule

// File: rtl/cart_bank_reg.sv
module cart_bank_reg #(
    parameter int unsigned DATA_W = cart_pkg::DATA_W,
    parameter int unsigned BANK_W = cart_pkg::PRG_BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic              hit,
    input  logic [DATA_W-1:0] data,
    output logic [BANK_W-1:0] bank
);
    typedef struct packed {
        logic              phi2;
        logic              hit;
        logic [BANK_W-1:0] data;
        logic [BANK_W-1:0] bank;
    } bank_state_t;

    localparam logic [BANK_W-1:0] LAST_BANK = '1;

    bank_state_t st_d, st_q;
    logic        fall;

    always_comb begin
        st_d      = st_q;
        st_d.phi2 = phi2;
        fall      = st_q.phi2 && !phi2;
        if (phi2) begin
            st_d.hit  = hit;
            st_d.data = data[BANK_W-1:0];
        end
        if (fall && st_q.hit) begin
            st_d.bank = st_q.data;
            st_d.hit  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.bank <= LAST_BANK;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank = st_q.bank;

    // R2: without a phase-2 fall the bank cannot move
    assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.phi2 && !phi2) |=> $stable(st_q.bank))
        else $error("bank changed without phase-2 fall");

    // R8: a fall that ends a non-matching cycle keeps the bank
    assert_bank_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phi2 && !phi2 && !st_q.hit) |=> $stable(st_q.bank))
        else $error("bank changed after unmatched cycle");
endmodule

// File: rtl/cart_prg_fm_mapper.sv
module cart_prg_fm_mapper #(
    parameter int unsigned ADDR_W = cart_pkg::ADDR_W,
    parameter int unsigned DATA_W = cart_pkg::DATA_W,
    parameter int unsigned BANK_W = cart_pkg::PRG_BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_rw,
    input  logic              cpu_phi2,
    input  logic              big_rom_en,
    output logic [BANK_W-1:0] prg_addr,
    output logic              rom_en,
    output logic              fm_en,
    output logic              fm_sel
);
    localparam int unsigned TOP = BANK_W - 1;

    logic              bank_hit;
    logic [BANK_W-1:0] bank;

    cart_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (cpu_addr),
        .rw       (cpu_rw),
        .phi2     (cpu_phi2),
        .bank_hit (bank_hit),
        .fm_hit   (fm_en),
        .fm_sel   (fm_sel),
        .rom_rd   (rom_en)
    );

    cart_bank_reg #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .phi2  (cpu_phi2),
        .hit   (bank_hit),
        .data  (cpu_data),
        .bank  (bank)
    );

    always_comb begin
        prg_addr      = bank;
        prg_addr[TOP] = bank[TOP] | ~big_rom_en;
    end

    assert_rom_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rw |-> !rom_en) else $error("ROM enabled during write");

    assert_fm_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fm_en |-> (cpu_phi2 && !cpu_rw)) else $error("FM enable outside write strobe");

    assert_fm_index_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fm_en && cpu_addr == 16'h9010) |-> !fm_sel) else $error("index port select wrong");

    assert_top_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !big_rom_en |-> prg_addr[TOP]) else $error("A18 not held high");
endmodule

// File: tb/sim_cart_prg_fm_mapper.sv
module sim_cart_prg_fm_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rw = 1'b1;
    logic        cpu_phi2 = 1'b0;
    logic        big_rom_en = 1'b1;
    logic [3:0]  prg_addr;
    logic        rom_en, fm_en, fm_sel;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cart_prg_fm_mapper u0 (.*);

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // full write cycle; next bus cycle starts at the phase-2 fall
    task automatic bus_write(logic [15:0] a, logic [7:0] d, int exp_fm, int exp_sel,
                             int exp_bank, string req);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_rw = 1'b0; cpu_phi2 = 1'b1;
        #1;
        check({req, " fm_en"}, fm_en, exp_fm);
        if (exp_fm == 1) check("R4 fm_sel", fm_sel, exp_sel);
        check("R7 rom_en low on write", rom_en, 0);
        @(negedge clk);
        cpu_phi2 = 1'b0; cpu_rw = 1'b1; cpu_addr = 16'h0000; cpu_data = 8'hFF;
        @(negedge clk);
        @(negedge clk);
        check({req, " bank"}, prg_addr, exp_bank);
    endtask

    task automatic bus_read(logic [15:0] a, int exp_rom, string req);
        @(negedge clk);
        cpu_addr = a; cpu_rw = 1'b1; cpu_phi2 = 1'b1;
        #1;
        check(req, rom_en, exp_rom);
        @(negedge clk);
        cpu_phi2 = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R5 reset bank", prg_addr, 15);
        check("R7 rom_en at $0000", rom_en, 0);
        check("R3 fm_en idle", fm_en, 0);
    endtask

    task automatic t_bank_writes();
        bus_write(16'h8000, 8'h05, 0, 0, 5, "R1 R2 $8000");
        bus_write(16'h8F8F, 8'hFA, 0, 0, 10, "R1 alias $8F8F");
        bus_write(16'h8010, 8'h03, 0, 0, 10, "R8 A4 set");
        bus_write(16'hC000, 8'h03, 0, 0, 10, "R8 A14 set");
        bus_write(16'h8040, 8'h03, 0, 0, 10, "R8 A6 set");
        bus_read(16'h8000, 1, "R7 read $8000");
        @(negedge clk);
        check("R8 read leaves bank", prg_addr, 10);
    endtask

    task automatic t_fm();
        bus_write(16'h9010, 8'h20, 1, 0, 10, "R3 $9010");
        bus_write(16'h9030, 8'h01, 1, 1, 10, "R3 $9030");
        bus_write(16'h9F1F, 8'h01, 1, 0, 10, "R3 alias $9F1F");
        bus_write(16'h9050, 8'h01, 0, 0, 10, "R3 A6 set");
        bus_write(16'h9000, 8'h01, 0, 0, 10, "R3 A4 clear");
        @(negedge clk);
        cpu_addr = 16'h9010; cpu_rw = 1'b0; cpu_phi2 = 1'b0;
        #1;
        check("R3 no enable with phi2 low", fm_en, 0);
        @(negedge clk);
        cpu_rw = 1'b1;
    endtask

    task automatic t_top_line();
        bus_write(16'h8000, 8'h03, 0, 0, 3, "R2 bank 3");
        @(negedge clk);
        big_rom_en = 1'b0;
        #1;
        check("R6 A18 forced high", prg_addr, 11);
        big_rom_en = 1'b1;
        #1;
        check("R6 A18 from register", prg_addr, 3);
    endtask

    task automatic t_rom_en();
        bus_read(16'hC123, 1, "R7 read $C123");
        bus_read(16'h7FFF, 0, "R7 read $7FFF");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bank_writes();
        t_fm();
        t_top_line();
        t_rom_en();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule